// File: doc/BRIEF.md
# Transceiver Slot Sequencer

This controller walks an external 2.4 GHz radio through its operating states. It starts from power down, raises the supply enables and waits for the supplies to settle. It then writes a configuration word over a three-wire serial port and waits for the synthesizer to lock. After that it runs receive or transmit slots. Every wait is counted in system clock cycles, and the counts come from the clock frequency at elaboration.

The host pulses request inputs: power up, power down, program, receive, transmit and end of slot. A receive or transmit request that arrives while programming or lock settling is still running is held and served as soon as settling completes. Each transmit slot opens with an alternating preamble and then passes the host's payload bit through. A power-down request overrides everything else.

Top module: `radio_slot_seq`

## Requirements
- R1: After reset, supply_en_o, rf_core_en_o, ref_clk_en_o, tx_key_o, rx_active_o, tx_bit_o and busy_o are 0 and ser_en_n_o is 1.
- R2: A pwr_up_req pulse in power down raises supply_en_o and rf_core_en_o on the next cycle. busy_o then stays high for exactly PUP_CYC = ceil(CLK_HZ*PUP_US/1e6) cycles, and ref_clk_en_o stays 0 during that wait and in the powered, unprogrammed idle state.
- R3: A cfg_req pulse while powered and idle, or while ready, drives ser_en_n_o low on the next cycle. It stays low for exactly 2*SCK_HALF*CFG_W cycles, with ref_clk_en_o high throughout.
- R4: While ser_en_n_o is low there are exactly CFG_W rising edges on ser_clk_o. At each rising edge ser_dat_o carries the next bit of cfg_word, most significant bit first. ser_dat_o does not change while ser_clk_o is high.
- R5: After ser_en_n_o returns high, busy_o stays high for exactly PLL_CYC = ceil(CLK_HZ*PLL_US/1e6) cycles, and no slot starts during that time.
- R6: An rx_req or tx_req pulse during programming or settling is held. The slot starts in the first cycle busy_o is low. If both were requested, transmit wins.
- R7: In the ready state an rx_req pulse sets rx_active_o on the next cycle. ref_clk_en_o stays high during every slot, and a slot_end pulse ends the slot on the next cycle while ref_clk_en_o stays high.
- R8: A tx_req pulse in the ready state sets tx_key_o on the next cycle. tx_bit_o then gives PRE_LEN preamble bits 1,0,1,0,... starting with 1, one per cycle, and follows tx_payload after that. tx_bit_o is 0 outside transmit slots.
- R9: rx_req and tx_req in power down or in the powered, unprogrammed idle state are ignored: tx_key_o and rx_active_o stay 0.
- R10: A pdn_req pulse in any state takes priority over every other request. On the next cycle supply_en_o, rf_core_en_o, ref_clk_en_o and tx_key_o are 0 and ser_en_n_o is 1, and this includes aborting a serial write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up_req | input | 1 | Pulse: leave power down |
| pdn_req | input | 1 | Pulse: return to power down from any state |
| cfg_req | input | 1 | Pulse: write cfg_word to the radio |
| cfg_word | input | CFG_W | Configuration word to shift out |
| rx_req | input | 1 | Pulse: start a receive slot |
| tx_req | input | 1 | Pulse: start a transmit slot |
| slot_end | input | 1 | Pulse: end the active slot |
| tx_payload | input | 1 | Payload bit sent after the preamble |
| supply_en_o | output | 1 | Regulator supply enable |
| rf_core_en_o | output | 1 | Radio core enable |
| ser_en_n_o | output | 1 | Serial port enable, active low |
| ser_clk_o | output | 1 | Serial port clock |
| ser_dat_o | output | 1 | Serial port data |
| ref_clk_en_o | output | 1 | Reference clock gate |
| tx_key_o | output | 1 | Transmit-on strobe |
| tx_bit_o | output | 1 | Transmit data line |
| rx_active_o | output | 1 | Receive slot active |
| busy_o | output | 1 | Power-up, programming or lock settling in progress |

## Verification
Assertions check the relations that must hold on every cycle. A power-down request leaves everything off on the next cycle. The reference clock runs whenever the serial port is enabled or a slot is active. Serial data is steady while the serial clock is high. Preamble bits alternate, and slots begin only out of settling or ready. The exact lengths of the power-up wait, the serial write and the lock wait, the order of the shifted bits, the holding of requests and their priority, and ignored requests can only be shown by the bench. It sweeps several configuration words, request timings and payload values on a small configuration and computes the expected cycle counts from the parameters.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    ST_DOWN,
    ST_PUP,
    ST_IDLE,
    ST_PROG,
    ST_SETTLE,
    ST_READY,
    ST_RX,
    ST_TX
  } rss_state_e;

  // Round a microsecond interval up to whole clock cycles, never below one.
  function automatic int unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/rss_settle_timer.sv
module rss_settle_timer #(
  parameter int unsigned LIM_A = 4000,
  parameter int unsigned LIM_B = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_b,
  output logic done
);
  localparam int unsigned MAXL = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int unsigned CW   = (MAXL > 1) ? $clog2(MAXL + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != CW'(MAXL));
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = sel_b ? (cnt_q == CW'(LIM_B - 1)) : (cnt_q == CW'(LIM_A - 1));

endmodule

// File: rtl/rss_ser_shift.sv
module rss_ser_shift #(
  parameter int unsigned W    = 24,
  parameter int unsigned HALF = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] word,
  output logic         en_n,
  output logic         sclk,
  output logic         sdat,
  output logic         done
);
  localparam int unsigned PER = 2 * HALF;
  localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int unsigned BW  = (W > 1) ? $clog2(W) : 1;

  logic          act_q, act_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bi_q, bi_d;
  logic [W-1:0]  sr_q, sr_d;
  logic          wrap;

  assign wrap = act_q && (ph_q == PW'(PER - 1));
  assign done = wrap && (bi_q == BW'(W - 1)) && !abort;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bi_d  = bi_q;
    sr_d  = sr_q;
    if (abort) begin
      act_d = 1'b0;
    end else if (start && !act_q) begin
      act_d = 1'b1;
      ph_d  = '0;
      bi_d  = '0;
      sr_d  = word;
    end else if (act_q) begin
      if (wrap) begin
        ph_d = '0;
        if (bi_q == BW'(W - 1)) begin
          act_d = 1'b0;
        end else begin
          bi_d = bi_q + 1'b1;
          sr_d = {sr_q[W-2:0], 1'b0};
        end
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bi_q  <= '0;
      sr_q  <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bi_q  <= bi_d;
      sr_q  <= sr_d;
    end
  end

  assign en_n = !act_q;
  assign sclk = act_q && (ph_q >= PW'(HALF));
  assign sdat = act_q && sr_q[W-1];

  // R4: data is held for the whole high phase of the serial clock
  a_r4_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));

  // R3: the enable stays low from start until the last bit completes
  a_r3_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wrap && !abort) |=> !en_n);

endmodule

// File: rtl/rss_preamble.sv
module rss_preamble #(
  parameter int unsigned PRE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic payload,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          in_pre;

  assign in_pre = (cnt_q < CW'(PRE_LEN));

  always_comb begin
    cnt_en = start || (active && in_pre);
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bit_o = active && (in_pre ? !cnt_q[0] : payload);

  // R8: consecutive preamble bits alternate
  a_r8_preamble_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && in_pre && (cnt_q != '0)) |-> (bit_o != $past(bit_o)));

endmodule

// File: rtl/radio_slot_seq.sv
module radio_slot_seq
  import rss_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned     PUP_US   = 40,
  parameter int unsigned     PLL_US   = 200,
  parameter int unsigned     CFG_W    = 24,
  parameter int unsigned     SCK_HALF = 4,
  parameter int unsigned     PRE_LEN  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up_req,
  input  logic             pdn_req,
  input  logic             cfg_req,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             slot_end,
  input  logic             tx_payload,
  output logic             supply_en_o,
  output logic             rf_core_en_o,
  output logic             ser_en_n_o,
  output logic             ser_clk_o,
  output logic             ser_dat_o,
  output logic             ref_clk_en_o,
  output logic             tx_key_o,
  output logic             tx_bit_o,
  output logic             rx_active_o,
  output logic             busy_o
);
  localparam int unsigned PUP_CYC = us_to_cycles(CLK_HZ, longint'(PUP_US));
  localparam int unsigned PLL_CYC = us_to_cycles(CLK_HZ, longint'(PLL_US));

  rss_state_e st_q, st_d;
  logic       pend_tx_q, pend_tx_d, pend_rx_q, pend_rx_d;
  logic       tmr_start, tmr_done;
  logic       sh_start, sh_done;
  logic       pre_start;
  logic       holding_now, holding_next;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DOWN:   if (pwr_up_req) st_d = ST_PUP;
      ST_PUP:    if (tmr_done)   st_d = ST_IDLE;
      ST_IDLE:   if (cfg_req)    st_d = ST_PROG;
      ST_PROG:   if (sh_done)    st_d = ST_SETTLE;
      ST_SETTLE: begin
        if (tmr_done) begin
          if (pend_tx_q || tx_req)      st_d = ST_TX;
          else if (pend_rx_q || rx_req) st_d = ST_RX;
          else                          st_d = ST_READY;
        end
      end
      ST_READY: begin
        if (cfg_req)     st_d = ST_PROG;
        else if (tx_req) st_d = ST_TX;
        else if (rx_req) st_d = ST_RX;
      end
      ST_RX:     if (slot_end) st_d = ST_READY;
      ST_TX:     if (slot_end) st_d = ST_READY;
      default:   st_d = ST_DOWN;
    endcase
    if (pdn_req) st_d = ST_DOWN;
  end

  // slot requests held while programming or settling
  always_comb begin
    holding_now  = (st_q == ST_PROG) || (st_q == ST_SETTLE);
    holding_next = (st_d == ST_PROG) || (st_d == ST_SETTLE);
    pend_tx_d    = holding_now && holding_next && (pend_tx_q || tx_req);
    pend_rx_d    = holding_now && holding_next && (pend_rx_q || rx_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_DOWN;
      pend_tx_q <= 1'b0;
      pend_rx_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_tx_q <= pend_tx_d;
      pend_rx_q <= pend_rx_d;
    end
  end

  assign tmr_start = ((st_d == ST_PUP) && (st_q != ST_PUP)) ||
                     ((st_d == ST_SETTLE) && (st_q != ST_SETTLE));
  assign sh_start  = (st_d == ST_PROG) && (st_q != ST_PROG);
  assign pre_start = (st_d == ST_TX) && (st_q != ST_TX);

  rss_settle_timer #(
    .LIM_A (PUP_CYC),
    .LIM_B (PLL_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .sel_b (st_q == ST_SETTLE),
    .done  (tmr_done)
  );

  rss_ser_shift #(
    .W    (CFG_W),
    .HALF (SCK_HALF)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .abort (pdn_req),
    .word  (cfg_word),
    .en_n  (ser_en_n_o),
    .sclk  (ser_clk_o),
    .sdat  (ser_dat_o),
    .done  (sh_done)
  );

  rss_preamble #(
    .PRE_LEN (PRE_LEN)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (pre_start),
    .active  (st_q == ST_TX),
    .payload (tx_payload),
    .bit_o   (tx_bit_o)
  );

  assign supply_en_o  = (st_q != ST_DOWN);
  assign rf_core_en_o = (st_q != ST_DOWN);
  assign ref_clk_en_o = (st_q == ST_PROG) || (st_q == ST_SETTLE) || (st_q == ST_READY) ||
                        (st_q == ST_RX) || (st_q == ST_TX);
  assign tx_key_o     = (st_q == ST_TX);
  assign rx_active_o  = (st_q == ST_RX);
  assign busy_o       = (st_q == ST_PUP) || (st_q == ST_PROG) || (st_q == ST_SETTLE);

  // R10: power-down leaves everything off on the next cycle
  a_r10_pdn_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_req |=> (!supply_en_o && !rf_core_en_o && !ref_clk_en_o && !tx_key_o && ser_en_n_o));

  // R3: reference clock runs while the serial port is enabled
  a_r3_ref_during_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en_n_o |-> ref_clk_en_o);

  // R7: reference clock runs during any slot
  a_r7_ref_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_key_o || rx_active_o) |-> ref_clk_en_o);

  // R6: a slot starts only out of settling or ready
  a_r6_slot_origin: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_key_o) || $rose(rx_active_o)) |->
      (($past(st_q) == ST_SETTLE) || ($past(st_q) == ST_READY)));

  // R9: no slot follows power down or unprogrammed idle
  a_r9_no_slot_unprogrammed: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DOWN) || (st_q == ST_IDLE)) |=> (!tx_key_o && !rx_active_o));

endmodule

// File: tb/tb_radio_slot_seq.sv
module tb_radio_slot_seq;
  localparam int W    = 8;
  localparam int HALF = 1;
  localparam int PRE  = 8;
  localparam int PUPC = 40;   // 40 us at 1 MHz
  localparam int PLLC = 200;  // 200 us at 1 MHz

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_up_req, pdn_req, cfg_req, rx_req, tx_req, slot_end, tx_payload;
  logic [W-1:0] cfg_word;
  logic supply_en_o, rf_core_en_o, ser_en_n_o, ser_clk_o, ser_dat_o;
  logic ref_clk_en_o, tx_key_o, tx_bit_o, rx_active_o, busy_o;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [W-1:0] cap;
  int ncap;

  always #5 clk = ~clk;

  radio_slot_seq #(
    .CLK_HZ(1_000_000), .PUP_US(40), .PLL_US(200),
    .CFG_W(W), .SCK_HALF(HALF), .PRE_LEN(PRE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pdn_req(pdn_req),
    .cfg_req(cfg_req), .cfg_word(cfg_word), .rx_req(rx_req), .tx_req(tx_req),
    .slot_end(slot_end), .tx_payload(tx_payload),
    .supply_en_o(supply_en_o), .rf_core_en_o(rf_core_en_o), .ser_en_n_o(ser_en_n_o),
    .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o), .ref_clk_en_o(ref_clk_en_o),
    .tx_key_o(tx_key_o), .tx_bit_o(tx_bit_o), .rx_active_o(rx_active_o), .busy_o(busy_o)
  );

  always @(posedge ser_clk_o) begin
    if (!ser_en_n_o) begin
      cap = {cap[W-2:0], ser_dat_o};
      ncap++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic power_up;
    pwr_up_req = 1'b1; tick; pwr_up_req = 1'b0;
    chk("R2 supply_en", int'(supply_en_o), 1);
    chk("R2 rf_core_en", int'(rf_core_en_o), 1);
    chk("R2 ref off in wait", int'(ref_clk_en_o), 0);
    begin
      int n = 0;
      while (busy_o && n < 1000) begin n++; tick; end
      chk("R2 power-up wait cycles", n, PUPC);
    end
    chk("R2 ref off in idle", int'(ref_clk_en_o), 0);
  endtask

  // inj: 0 none, 1 rx, 2 tx, 3 both, injected during settling
  task automatic program_word(input logic [W-1:0] w, input int inj);
    int n;
    int bad;
    cap = '0; ncap = 0;
    cfg_word = w; cfg_req = 1'b1; tick; cfg_req = 1'b0;
    chk("R3 enable low", int'(ser_en_n_o), 0);
    chk("R3 ref on", int'(ref_clk_en_o), 1);
    n = 0; bad = 0;
    while (!ser_en_n_o && n < 1000) begin
      if (!ref_clk_en_o) bad++;
      n++; tick;
    end
    chk("R3 enable low cycles", n, 2 * HALF * W);
    chk("R3 ref during write", bad, 0);
    chk("R4 shifted word", int'(cap), int'(w));
    chk("R4 clock edges", ncap, W);
    n = 0; bad = 0;
    while (busy_o && n < 1000) begin
      if (n == 50) begin rx_req = inj[0]; tx_req = inj[1]; end
      if (n == 51) begin rx_req = 1'b0; tx_req = 1'b0; end
      if (tx_key_o || rx_active_o) bad++;
      n++; tick;
    end
    rx_req = 1'b0; tx_req = 1'b0;
    chk("R5 settle cycles", n, PLLC);
    chk("R5 no slot while settling", bad, 0);
    chk("R6 held tx", int'(tx_key_o), inj[1] ? 1 : 0);
    chk("R6 held rx", int'(rx_active_o), (!inj[1] && inj[0]) ? 1 : 0);
  endtask

  task automatic check_tx(input logic pay);
    tx_payload = pay;
    for (int i = 0; i < PRE + 4; i++) begin
      chk("R8 tx_bit", int'(tx_bit_o), (i < PRE) ? ((i % 2 == 0) ? 1 : 0) : int'(pay));
      chk("R8 tx_key held", int'(tx_key_o), 1);
      tick;
    end
  endtask

  task automatic end_slot;
    slot_end = 1'b1; tick; slot_end = 1'b0;
    chk("R7 slot ended tx", int'(tx_key_o), 0);
    chk("R7 slot ended rx", int'(rx_active_o), 0);
    chk("R7 ref stays on in ready", int'(ref_clk_en_o), 1);
    chk("R8 tx_bit idle", int'(tx_bit_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pwr_up_req = 0; pdn_req = 0; cfg_req = 0; rx_req = 0; tx_req = 0;
    slot_end = 0; tx_payload = 0; cfg_word = '0; cap = '0; ncap = 0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R1 reset state
    chk("R1 supply_en", int'(supply_en_o), 0);
    chk("R1 rf_core_en", int'(rf_core_en_o), 0);
    chk("R1 ref", int'(ref_clk_en_o), 0);
    chk("R1 tx_key", int'(tx_key_o), 0);
    chk("R1 rx_active", int'(rx_active_o), 0);
    chk("R1 tx_bit", int'(tx_bit_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 ser_en_n", int'(ser_en_n_o), 1);

    // R9 requests in power down ignored
    tx_req = 1; rx_req = 1; tick; tx_req = 0; rx_req = 0;
    chk("R9 down tx ignored", int'(tx_key_o), 0);
    chk("R9 down rx ignored", int'(rx_active_o), 0);
    chk("R9 down stays unpowered", int'(supply_en_o), 0);

    power_up();

    // R9 requests in unprogrammed idle ignored
    tx_req = 1; tick; tx_req = 0;
    chk("R9 idle tx ignored", int'(tx_key_o), 0);
    rx_req = 1; tick; rx_req = 0;
    chk("R9 idle rx ignored", int'(rx_active_o), 0);
    chk("R9 idle not busy", int'(busy_o), 0);

    // programming sweep, no held requests
    program_word(8'hA5, 0);
    program_word(8'h3C, 0);
    program_word(8'h00, 0);
    program_word(8'hFF, 0);

    // R7 direct receive slot
    rx_req = 1; tick; rx_req = 0;
    chk("R7 rx active", int'(rx_active_o), 1);
    chk("R7 ref in rx", int'(ref_clk_en_o), 1);
    end_slot();

    // R8 direct transmit slot, payload 1 then 0
    tx_req = 1; tick; tx_req = 0;
    check_tx(1'b1);
    end_slot();
    tx_req = 1; tick; tx_req = 0;
    check_tx(1'b0);
    end_slot();

    // R6 held requests during settling
    program_word(8'h81, 1);
    end_slot();
    program_word(8'h5A, 2);
    check_tx(1'b1);
    end_slot();
    program_word(8'hC3, 3);
    check_tx(1'b0);

    // R10 power down from transmit beats slot_end and cfg_req
    pdn_req = 1; slot_end = 1; cfg_req = 1; tick;
    pdn_req = 0; slot_end = 0; cfg_req = 0;
    chk("R10 supply off", int'(supply_en_o), 0);
    chk("R10 core off", int'(rf_core_en_o), 0);
    chk("R10 ref off", int'(ref_clk_en_o), 0);
    chk("R10 tx off", int'(tx_key_o), 0);
    chk("R10 ser_en_n high", int'(ser_en_n_o), 1);

    // R10 power down aborts a serial write
    power_up();
    cfg_word = 8'h96; cfg_req = 1; tick; cfg_req = 0;
    repeat (5) tick;
    chk("R10 write in progress", int'(ser_en_n_o), 0);
    pdn_req = 1; tick; pdn_req = 0;
    chk("R10 abort ser_en_n", int'(ser_en_n_o), 1);
    chk("R10 abort supply", int'(supply_en_o), 0);
    chk("R10 abort ref", int'(ref_clk_en_o), 0);
    chk("R10 abort busy", int'(busy_o), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule